// File: doc/BRIEF.md
# Selectable Cache Replacement Unit

This block picks the way to evict in one set of an m-way set-associative cache, where m is a power of two from 2 to 8. The surrounding cache controller presents the set index of the current access, pulses a hit strobe with the way that hit, or pulses a miss strobe when a line is being filled. The unit answers with the victim way for the indexed set. It holds all replacement state itself. It keeps no tags, no data and no valid bits.

A parameter selects one of three policies. All three use the same ports.
- **Random**: one wrapping counter, shared by every set, that advances on every clock.
- **Round-robin (FIFO)**: one pointer per set that advances only on a miss to that set.
- **Tree pseudo-LRU**: m-1 direction bits per set, arranged as a binary tree.

An optional override input lets the controller force the victim, for example to fill an invalid way. The forced way is then also the way the state update treats as filled.

Top module: `repl_sel_top`

## Requirements
- R1: After reset every piece of replacement state is zero, so with the override off the victim is way 0 for every set index.
- R2: Random policy: one counter shared by all sets starts at 0 and advances by one on every clock edge out of reset, wrapping from WAYS-1 to 0. With the override off, the victim for any set equals the counter.
- R3: Round-robin policy: each set has a pointer that is the victim for that set. It advances by one, wrapping, on a clock edge with the miss strobe for that set. Hits, and misses to other sets, leave it unchanged.
- R4: Pseudo-LRU policy: each set stores WAYS-1 node bits. Node n (root n=1, children 2n and 2n+1) is at bit n-1, and the leaf nodes WAYS to 2*WAYS-1 stand for ways 0 to WAYS-1. The victim is found by starting at the root and stepping to child 2n plus the node bit, so bit value 0 points to the lower-numbered half.
- R5: Pseudo-LRU: a hit sets every node bit on the path to the hit way so that it points to the other subtree. The next victim for that set is therefore never the hit way.
- R6: Pseudo-LRU: a miss marks the filled way (the victim output in that cycle) as most recently used, by the same rule as a hit. Repeated misses to one 4-way set with no hits give victims 0, 2, 1, 3, 0.
- R7: While the override valid input is high, the victim output equals the override way input. A miss in that cycle fills the override way: the pseudo-LRU tree marks that way, and the round-robin pointer still advances by one.
- R8: When the hit and miss strobes are both high in one cycle, the miss update is applied and the hit is ignored.
- R9: With WAYS=2 the pseudo-LRU state is one bit per set, and the victim is the way other than the one last hit or filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_i | input | $clog2(SETS) | Set index of the current access |
| hit_i | input | 1 | Hit strobe; updates state on the clock edge |
| hit_way_i | input | $clog2(WAYS) | Way that hit |
| miss_i | input | 1 | Miss/fill strobe; updates state on the clock edge |
| inv_valid_i | input | 1 | Override enable: forces the victim |
| inv_way_i | input | $clog2(WAYS) | Way to force when the override is enabled |
| victim_o | output | $clog2(WAYS) | Victim way for the indexed set (combinational) |

## Verification
The assertions check, on every cycle, properties that relate one cycle to the next:
- the override mux;
- the random counter stepping by one;
- a round-robin pointer staying put without a miss, and stepping by one after a miss to the same set;
- a pseudo-LRU victim never naming the way just hit or just filled in that set.

Other behaviour needs the bench's reference model across long sequences: the reset state, the exact tree walk order (such as the 0, 2, 1, 3 fill order), isolation between sets, hit-and-miss priority, and wrap-around. The bench runs all four configurations side by side on the same stimulus.

// File: rtl/repl_pkg.sv
package repl_pkg;
    typedef enum logic [1:0] {
        POL_RAND = 2'd0,
        POL_FIFO = 2'd1,
        POL_PLRU = 2'd2
    } repl_policy_e;
endpackage

// File: rtl/repl_rand_ctr.sv
module repl_rand_ctr #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [WAY_W-1:0] victim_o
);
    typedef struct packed {
        logic [WAY_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    // Free-running counter; WAYS is a power of two, so it wraps naturally.
    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign victim_o = st_q.cnt;
endmodule

// File: rtl/repl_fifo_bank.sv
module repl_fifo_bank #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SET_W-1:0] set_i,
    input  logic             miss_i,
    output logic [WAY_W-1:0] victim_o
);
    typedef struct packed {
        logic [SETS-1:0][WAY_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    // Only the indexed set's pointer moves, and only on a miss.
    always_comb begin
        st_d = st_q;
        if (miss_i) begin
            st_d.ptr[set_i] = st_q.ptr[set_i] + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign victim_o = st_q.ptr[set_i];
endmodule

// File: rtl/repl_plru_bank.sv
module repl_plru_bank #(
    parameter int WAYS = 4,
    parameter int SETS = 16,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS),
    localparam int NODES = WAYS - 1,
    localparam int LVLS  = $clog2(WAYS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SET_W-1:0] set_i,
    input  logic             hit_i,
    input  logic [WAY_W-1:0] hit_way_i,
    input  logic             miss_i,
    input  logic [WAY_W-1:0] fill_way_i,
    output logic [WAY_W-1:0] victim_o
);
    typedef logic [NODES-1:0] row_t;

    typedef struct packed {
        logic [SETS-1:0][NODES-1:0] tree;
    } st_t;

    st_t st_d, st_q;

    // Heap-numbered walk: node n at bit n-1, children 2n / 2n+1.
    function automatic logic [WAY_W-1:0] walk_victim(row_t r);
        int unsigned node;
        node = 1;
        for (int l = 0; l < LVLS; l++) begin
            node = node * 2 + int'(r[node-1]);
        end
        return WAY_W'(node - WAYS);
    endfunction

    // Point every node on the path away from the touched way.
    function automatic row_t mark_recent(row_t r, logic [WAY_W-1:0] w);
        int unsigned node;
        logic        dir;
        node = 1;
        for (int l = 0; l < LVLS; l++) begin
            dir       = w[LVLS-1-l];
            r[node-1] = ~dir;
            node      = node * 2 + int'(dir);
        end
        return r;
    endfunction

    // A miss takes precedence over a hit raised in the same cycle.
    always_comb begin
        st_d = st_q;
        if (miss_i) begin
            st_d.tree[set_i] = mark_recent(st_q.tree[set_i], fill_way_i);
        end else if (hit_i) begin
            st_d.tree[set_i] = mark_recent(st_q.tree[set_i], hit_way_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign victim_o = walk_victim(st_q.tree[set_i]);
endmodule

// File: rtl/repl_sel_top.sv
module repl_sel_top #(
    parameter int                    WAYS   = 4,
    parameter int                    SETS   = 16,
    parameter repl_pkg::repl_policy_e POLICY = repl_pkg::POL_PLRU,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SET_W-1:0] set_i,
    input  logic             hit_i,
    input  logic [WAY_W-1:0] hit_way_i,
    input  logic             miss_i,
    input  logic             inv_valid_i,
    input  logic [WAY_W-1:0] inv_way_i,
    output logic [WAY_W-1:0] victim_o
);
    logic [WAY_W-1:0] pol_victim;

    generate
        if (POLICY == repl_pkg::POL_RAND) begin : g_rand
            logic unused_ok;
            assign unused_ok = ^{set_i, hit_i, hit_way_i, miss_i};
            repl_rand_ctr #(.WAYS(WAYS)) rand_i (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .victim_o (pol_victim)
            );
        end else if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
            logic unused_ok;
            assign unused_ok = ^{hit_i, hit_way_i};
            repl_fifo_bank #(.WAYS(WAYS), .SETS(SETS)) fifo_i (
                .clk_i    (clk_i),
                .rst_ni   (rst_ni),
                .set_i    (set_i),
                .miss_i   (miss_i),
                .victim_o (pol_victim)
            );
        end else begin : g_plru
            repl_plru_bank #(.WAYS(WAYS), .SETS(SETS)) plru_i (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .set_i      (set_i),
                .hit_i      (hit_i),
                .hit_way_i  (hit_way_i),
                .miss_i     (miss_i),
                .fill_way_i (victim_o),
                .victim_o   (pol_victim)
            );
        end
    endgenerate

    // The override also decides which way a concurrent miss fills.
    assign victim_o = inv_valid_i ? inv_way_i : pol_victim;
endmodule

// File: rtl/repl_sel_chk.sv
module repl_sel_chk #(
    parameter int                    WAYS   = 4,
    parameter int                    SETS   = 16,
    parameter repl_pkg::repl_policy_e POLICY = repl_pkg::POL_PLRU,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [SET_W-1:0] set_i,
    input logic             hit_i,
    input logic [WAY_W-1:0] hit_way_i,
    input logic             miss_i,
    input logic             inv_valid_i,
    input logic [WAY_W-1:0] inv_way_i,
    input logic [WAY_W-1:0] victim_o
);
    AST_OVERRIDE_WAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inv_valid_i |-> victim_o == inv_way_i); // R7

    generate
        if (POLICY == repl_pkg::POL_RAND) begin : g_rand
            AST_RAND_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && !inv_valid_i && !$past(inv_valid_i))
                |-> victim_o == WAY_W'($past(victim_o) + 1'b1)); // R2
        end else if (POLICY == repl_pkg::POL_FIFO) begin : g_fifo
            AST_FIFO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && !$past(miss_i) && set_i == $past(set_i)
                 && !inv_valid_i && !$past(inv_valid_i)) |-> $stable(victim_o)); // R3
            AST_FIFO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $past(miss_i) && set_i == $past(set_i)
                 && !inv_valid_i && !$past(inv_valid_i))
                |-> victim_o == WAY_W'($past(victim_o) + 1'b1)); // R3
        end else begin : g_plru
            AST_PLRU_HIT_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $past(hit_i) && !$past(miss_i)
                 && set_i == $past(set_i) && !inv_valid_i)
                |-> victim_o != $past(hit_way_i)); // R5
            AST_PLRU_FILL_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                ($past(rst_ni) && $past(miss_i) && set_i == $past(set_i) && !inv_valid_i)
                |-> victim_o != $past(victim_o)); // R6
        end
    endgenerate
endmodule

bind repl_sel_top repl_sel_chk #(.WAYS(WAYS), .SETS(SETS), .POLICY(POLICY)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_i),
    .hit_i       (hit_i),
    .hit_way_i   (hit_way_i),
    .miss_i      (miss_i),
    .inv_valid_i (inv_valid_i),
    .inv_way_i   (inv_way_i),
    .victim_o    (victim_o)
);

// File: tb/repl_sel_top_tb_top.sv
module repl_sel_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 4;
    localparam int S = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] set_s = '0;
    logic       hit_s = 1'b0, miss_s = 1'b0, iv_s = 1'b0;
    logic [1:0] hw_s = '0, iw_s = '0;
    logic [1:0] v_rnd, v_fifo, v_plru;
    logic       v_p2;

    always #2 clk = ~clk;

    repl_sel_top #(.WAYS(W), .SETS(S), .POLICY(repl_pkg::POL_RAND)) dut_rnd_i (
        .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .hit_i(hit_s), .hit_way_i(hw_s),
        .miss_i(miss_s), .inv_valid_i(iv_s), .inv_way_i(iw_s), .victim_o(v_rnd));
    repl_sel_top #(.WAYS(W), .SETS(S), .POLICY(repl_pkg::POL_FIFO)) dut_fifo_i (
        .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .hit_i(hit_s), .hit_way_i(hw_s),
        .miss_i(miss_s), .inv_valid_i(iv_s), .inv_way_i(iw_s), .victim_o(v_fifo));
    repl_sel_top #(.WAYS(W), .SETS(S), .POLICY(repl_pkg::POL_PLRU)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .hit_i(hit_s), .hit_way_i(hw_s),
        .miss_i(miss_s), .inv_valid_i(iv_s), .inv_way_i(iw_s), .victim_o(v_plru));
    repl_sel_top #(.WAYS(2), .SETS(S), .POLICY(repl_pkg::POL_PLRU)) dut_p2_i (
        .clk_i(clk), .rst_ni(rst_n), .set_i(set_s), .hit_i(hit_s), .hit_way_i(hw_s[0]),
        .miss_i(miss_s), .inv_valid_i(iv_s), .inv_way_i(iw_s[0]), .victim_o(v_p2));

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    int   rnd_m;
    int   fifo_m [S];
    logic [2:0] plru_m [S];   // [0]=root, [1]=ways 0/1, [2]=ways 2/3
    logic p2_m [S];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) rnd_m <= 0;
        else        rnd_m <= (rnd_m + 1) % W;
    end

    function automatic int plru_vic(logic [2:0] t);
        if (t[0]) return t[2] ? 3 : 2;
        return t[1] ? 1 : 0;
    endfunction

    function automatic logic [2:0] plru_upd(logic [2:0] t, int w);
        t[0] = (w < 2);
        if (w < 2) t[1] = (w == 0);
        else       t[2] = (w == 2);
        return t;
    endfunction

    task automatic chk(string req, string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0t: actual %0d expected %0d", req, tag, $time, act, exp);
        end
    endtask

    task automatic step(int s, bit h, int hw, bit m, bit iv, int iw, string tag);
        int e_rnd, e_fifo, e_plru, e_p2;
        @(negedge clk);
        set_s = 3'(s); hit_s = h; hw_s = 2'(hw); miss_s = m; iv_s = iv; iw_s = 2'(iw);
        #1;
        e_rnd  = iv ? iw : rnd_m;
        e_fifo = iv ? iw : fifo_m[s];
        e_plru = iv ? iw : plru_vic(plru_m[s]);
        e_p2   = iv ? (iw % 2) : int'(p2_m[s]);
        chk("R2", tag, int'(v_rnd),  e_rnd);
        chk("R3", tag, int'(v_fifo), e_fifo);
        chk("R4", tag, int'(v_plru), e_plru);
        chk("R9", tag, int'(v_p2),   e_p2);
        @(posedge clk);
        if (m) begin
            fifo_m[s] = (fifo_m[s] + 1) % W;
            plru_m[s] = plru_upd(plru_m[s], e_plru);
            p2_m[s]   = (e_p2 == 0);
        end else if (h) begin
            plru_m[s] = plru_upd(plru_m[s], hw);
            p2_m[s]   = ((hw % 2) == 0);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < S; i++) begin
            fifo_m[i] = 0; plru_m[i] = '0; p2_m[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all victims zero before the first edge out of reset
        for (int s = 0; s < S; s++) begin
            set_s = 3'(s);
            #0.2;
            chk("R1", "reset rnd",  int'(v_rnd),  0);
            chk("R1", "reset fifo", int'(v_fifo), 0);
            chk("R1", "reset plru", int'(v_plru), 0);
            chk("R1", "reset p2",   int'(v_p2),   0);
        end
        // R3: repeated misses in set 5 wrap the pointer; set 6 untouched
        for (int k = 0; k < 6; k++) step(5, 0, 0, 1, 0, 0, "R3 miss wrap");
        step(6, 1, 2, 0, 0, 0, "R3 other set + hit");
        // R5: hits 0,1,2,3 then 0 in set 3
        for (int w = 0; w < W; w++) step(3, 1, w, 0, 0, 0, "R5 hit sweep");
        step(3, 1, 0, 0, 0, 0, "R5 rehit");
        step(3, 0, 0, 0, 0, 0, "R5 after rehit");
        // R6: misses alone in set 2 give 0,2,1,3,0
        for (int k = 0; k < 5; k++) step(2, 0, 0, 1, 0, 0, "R6 fill order");
        // R7: override with miss in set 1
        step(1, 0, 0, 1, 1, 3, "R7 override fill");
        step(1, 0, 0, 0, 0, 0, "R7 after override");
        step(1, 0, 0, 1, 1, 0, "R7 override fill 0");
        step(1, 0, 0, 0, 0, 0, "R7 after override 0");
        // R8: hit and miss together in set 4
        step(4, 1, 0, 1, 0, 0, "R8 both strobes");
        step(4, 0, 0, 0, 0, 0, "R8 after both");
        // R9: alternating hits in a 2-way set
        for (int k = 0; k < 4; k++) step(7, 1, k % 2, 0, 0, 0, "R9 alternate");
        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom % 4);
            step(int'($urandom % S), (r == 1) || (r == 3), int'($urandom % W),
                 (r >= 2), ($urandom % 8) == 0, int'($urandom % W), "random mix");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule